// File: doc/BRIEF.md
# PHY Register Access Controller

This block gives host software a single 32-bit command word for reaching the few internal registers of an attached physical-layer chip. The host writes a 4-bit register number, an 8-bit value, and one of two command bits: fetch or store. The controller turns that into a single request on a parallel valid/acknowledge port toward the PHY. For a fetch, it then waits for the PHY's answer and captures both the returned value and the register number the PHY echoes back. A separate read-done flag tells the host that these captured fields are valid.

When the bus's self-identification phase finishes, the controller fetches PHY register 0 by itself, without any host command. Only one transaction is ever outstanding. A host command that arrives while the controller is occupied is discarded.

The sequencer has three states. `ST_IDLE` has nothing in flight. `ST_SEND` holds the request valid until the PHY acknowledges it. `ST_WAIT` waits for the PHY's fetch response. The transitions are:

- IDLE→SEND, launch-host: a command bit is set.
- IDLE→SEND, launch-auto: the self-ID fetch is pending, no command bit is set, and no host command is being accepted in that cycle.
- SEND→IDLE, store-acked: a store is acknowledged.
- SEND→WAIT, fetch-acked: a fetch is acknowledged.
- WAIT→IDLE, response-captured: the PHY's response arrives.

Top module: `phy_reg_access_ctrl`

## Requirements
- R1: After reset, the command word reads all zeros, `rx_done` is 0 and `req_valid` is 0.
- R2: A host write sets the fields of the command word, and the word reads them back in these positions: fetch command at bit 31, store command at bit 30, target register at bits 27..24, store value at bits 23..16. Bits 29..28 and 15..12 read 0.
- R3: A fetch command raises `req_valid` with `req_is_write`=0 and `req_addr` equal to the programmed register. The request and its fields stay unchanged until `req_ack`.
- R4: A store command raises `req_valid` with `req_is_write`=1, the programmed register and value. The controller waits for no response: it is idle again right after the acknowledge.
- R5: The command bit that launched a request reads 0 in the cycle after the request is acknowledged.
- R6: When a fetch response arrives (`rsp_valid`), its value appears in bits 7..0 and its echoed register in bits 11..8, and `rx_done` is set.
- R7: A pulse on `rx_done_clr` clears `rx_done`. A later completed fetch sets it again and overwrites bits 11..0.
- R8: If a host write sets both command bits, only the fetch is kept. Bit 31 reads 1, bit 30 reads 0, and no store request is ever sent.
- R9: A host write made while a command bit is still set, or while a request or response is outstanding, is ignored as a whole: no field of the word changes and no extra request is sent.
- R10: A `selfid_done` pulse causes one fetch of register 0 while both command bits read 0. Its response is captured as in R6.
- R11: An automatic fetch that falls due while a host command is in flight, or in the same cycle that a host command is accepted, is sent only after that host transaction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Current command word contents |
| rx_done_clr | input | 1 | Clears the read-done flag |
| rx_done | output | 1 | Read-done flag |
| selfid_done | input | 1 | One-cycle pulse at the end of self-ID |
| req_valid | output | 1 | Request to the PHY is valid |
| req_is_write | output | 1 | 1 = store, 0 = fetch |
| req_addr | output | 4 | PHY register number |
| req_data | output | 8 | Value to store |
| req_ack | input | 1 | PHY accepts the request |
| rsp_valid | input | 1 | PHY fetch response valid |
| rsp_addr | input | 4 | Echoed register number |
| rsp_data | input | 8 | Returned register value |

## Verification
A sequencer stuck outside `ST_IDLE` shows within two cycles of the next host write: the write is refused, so the readback fields do not change. A missing transition out of `ST_SEND` leaves `req_valid` high past the acknowledge edge. The bench samples each of these outcomes one cycle after the causing edge. A lost or never-cleared automatic-fetch pending bit shows as a missing or repeated register-0 request within a few cycles of the controller going idle. A capture path that misbehaves shows at once in bits 11..0 and in `rx_done` on the cycle after the response.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
    localparam int PA_W     = 4;
    localparam int PD_W     = 8;
    localparam int REG_W    = 32;
    localparam int RD_BIT   = 31;
    localparam int WR_BIT   = 30;
    localparam int ADDR_LSB = 24;
    localparam int WDAT_LSB = 16;
    localparam int RXA_LSB  = 8;
    localparam int RXD_LSB  = 0;
    localparam logic [PA_W-1:0] AUTO_REG = '0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } acc_state_e;
endpackage

// File: rtl/phy_acc_cmd_reg.sv
module phy_acc_cmd_reg
    import phy_acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [REG_W-1:0] host_wdata,
    input  logic             busy,
    input  logic             clr_cmd,
    input  logic             cap_en,
    input  logic [PA_W-1:0]  rsp_addr,
    input  logic [PD_W-1:0]  rsp_data,
    input  logic             flag_clr,
    output logic             cmd_rd,
    output logic             cmd_wr,
    output logic [PA_W-1:0]  cmd_addr,
    output logic [PD_W-1:0]  cmd_data,
    output logic             accept,
    output logic [REG_W-1:0] host_rdata,
    output logic             rx_done
);
    logic [PA_W-1:0] rx_addr_q;
    logic [PD_W-1:0] rx_data_q;

    assign accept = host_wr_en && !busy && !cmd_rd && !cmd_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_rd   <= 1'b0;
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
        end else if (accept) begin
            cmd_rd   <= host_wdata[RD_BIT];
            cmd_wr   <= host_wdata[WR_BIT] && !host_wdata[RD_BIT];
            cmd_addr <= host_wdata[ADDR_LSB +: PA_W];
            cmd_data <= host_wdata[WDAT_LSB +: PD_W];
        end else if (clr_cmd) begin
            cmd_rd <= 1'b0;
            cmd_wr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_addr_q <= '0;
            rx_data_q <= '0;
            rx_done   <= 1'b0;
        end else begin
            if (cap_en) begin
                rx_addr_q <= rsp_addr;
                rx_data_q <= rsp_data;
            end
            if (cap_en)        rx_done <= 1'b1;
            else if (flag_clr) rx_done <= 1'b0;
        end
    end

    always_comb begin
        host_rdata                        = '0;
        host_rdata[RD_BIT]                = cmd_rd;
        host_rdata[WR_BIT]                = cmd_wr;
        host_rdata[ADDR_LSB +: PA_W]      = cmd_addr;
        host_rdata[WDAT_LSB +: PD_W]      = cmd_data;
        host_rdata[RXA_LSB +: PA_W]       = rx_addr_q;
        host_rdata[RXD_LSB +: PD_W]       = rx_data_q;
    end
endmodule

// File: rtl/phy_acc_fsm.sv
module phy_acc_fsm
    import phy_acc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_rd,
    input  logic            cmd_wr,
    input  logic [PA_W-1:0] cmd_addr,
    input  logic [PD_W-1:0] cmd_data,
    input  logic            host_cmd_now,
    input  logic            selfid_done,
    input  logic            req_ack,
    input  logic            rsp_valid,
    output logic            busy,
    output logic            clr_cmd,
    output logic            cap_en,
    output logic            req_valid,
    output logic            req_is_write,
    output logic [PA_W-1:0] req_addr,
    output logic [PD_W-1:0] req_data
);
    acc_state_e      state_q, state_d;
    logic            pend_q;
    logic            lat_wr_q;
    logic [PA_W-1:0] lat_addr_q;
    logic [PD_W-1:0] lat_data_q;
    logic            launch_host, launch_auto;

    assign launch_host = (state_q == ST_IDLE) && (cmd_rd || cmd_wr);
    assign launch_auto = (state_q == ST_IDLE) && !cmd_rd && !cmd_wr
                         && !host_cmd_now && pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch_host || launch_auto) state_d = ST_SEND;
            ST_SEND: if (req_ack) state_d = lat_wr_q ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_q     <= 1'b0;
            lat_wr_q   <= 1'b0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (selfid_done)      pend_q <= 1'b1;
            else if (launch_auto) pend_q <= 1'b0;
            if (launch_host) begin
                lat_wr_q   <= cmd_wr;
                lat_addr_q <= cmd_addr;
                lat_data_q <= cmd_data;
            end else if (launch_auto) begin
                lat_wr_q   <= 1'b0;
                lat_addr_q <= AUTO_REG;
                lat_data_q <= '0;
            end
        end
    end

    always_comb begin
        busy         = (state_q != ST_IDLE);
        req_valid    = (state_q == ST_SEND);
        req_is_write = req_valid && lat_wr_q;
        req_addr     = lat_addr_q;
        req_data     = lat_data_q;
        clr_cmd      = (state_q == ST_SEND) && req_ack;
        cap_en       = (state_q == ST_WAIT) && rsp_valid;
    end
endmodule

// File: rtl/phy_reg_access_ctrl.sv
module phy_reg_access_ctrl
    import phy_acc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr_en,
    input  logic [REG_W-1:0] host_wdata,
    output logic [REG_W-1:0] host_rdata,
    input  logic             rx_done_clr,
    output logic             rx_done,
    input  logic             selfid_done,
    output logic             req_valid,
    output logic             req_is_write,
    output logic [PA_W-1:0]  req_addr,
    output logic [PD_W-1:0]  req_data,
    input  logic             req_ack,
    input  logic             rsp_valid,
    input  logic [PA_W-1:0]  rsp_addr,
    input  logic [PD_W-1:0]  rsp_data
);
    logic            busy, clr_cmd, cap_en, host_accept, host_cmd_now;
    logic            cmd_rd, cmd_wr;
    logic [PA_W-1:0] cmd_addr;
    logic [PD_W-1:0] cmd_data;

    assign host_cmd_now = host_accept && (host_wdata[RD_BIT] || host_wdata[WR_BIT]);

    phy_acc_cmd_reg u_cmd (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .busy(busy), .clr_cmd(clr_cmd), .cap_en(cap_en), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .flag_clr(rx_done_clr), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .accept(host_accept),
        .host_rdata(host_rdata), .rx_done(rx_done)
    );

    phy_acc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .host_cmd_now(host_cmd_now), .selfid_done(selfid_done),
        .req_ack(req_ack), .rsp_valid(rsp_valid), .busy(busy), .clr_cmd(clr_cmd),
        .cap_en(cap_en), .req_valid(req_valid), .req_is_write(req_is_write),
        .req_addr(req_addr), .req_data(req_data)
    );
endmodule

// File: rtl/phy_acc_chk.sv
module phy_acc_chk
    import phy_acc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_accept,
    input logic [REG_W-1:0] host_wdata,
    input logic [REG_W-1:0] host_rdata,
    input logic             rx_done,
    input logic             rx_done_clr,
    input logic             req_valid,
    input logic             req_is_write,
    input logic [PA_W-1:0]  req_addr,
    input logic [PD_W-1:0]  req_data,
    input logic             req_ack,
    input logic             rsp_valid
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_addr)
            && $stable(req_is_write) && $stable(req_data));

    // R5
    cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ack |=> host_rdata[RD_BIT] == 1'b0 && host_rdata[WR_BIT] == 1'b0);

    // R8
    rd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_accept && host_wdata[RD_BIT] |=> host_rdata[RD_BIT] && !host_rdata[WR_BIT]);

    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(rsp_valid));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_clr && !rsp_valid |=> !rx_done);

    // R10
    auto_reg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !host_rdata[RD_BIT] && !host_rdata[WR_BIT]
            |-> !req_is_write && req_addr == '0);
endmodule

bind phy_reg_access_ctrl phy_acc_chk i_chk (
    .clk(clk), .rst_n(rst_n), .host_accept(host_accept), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rx_done(rx_done), .rx_done_clr(rx_done_clr),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
    .req_data(req_data), .req_ack(req_ack), .rsp_valid(rsp_valid)
);

// File: tb/test_phy_reg_access_ctrl.sv
module test_phy_reg_access_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        rx_done_clr = 1'b0;
    logic        rx_done;
    logic        selfid_done = 1'b0;
    logic        req_valid, req_is_write;
    logic [3:0]  req_addr;
    logic [7:0]  req_data;
    logic        req_ack = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [3:0]  rsp_addr = '0;
    logic [7:0]  rsp_data = '0;
    int          n_tests = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #4 clk = ~clk;

    phy_reg_access_ctrl i_phy_reg_access_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .rx_done_clr(rx_done_clr), .rx_done(rx_done),
        .selfid_done(selfid_done), .req_valid(req_valid), .req_is_write(req_is_write),
        .req_addr(req_addr), .req_data(req_data), .req_ack(req_ack),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<=20000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input bit rd, input bit wr,
                                        input logic [3:0] a, input logic [7:0] d);
        return {rd, wr, 2'b00, a, d, 16'h0000};
    endfunction

    task automatic host_wr(input logic [31:0] d);
        @(negedge clk); host_wr_en = 1'b1; host_wdata = d;
        @(negedge clk); host_wr_en = 1'b0;
    endtask

    task automatic wait_req(input string req);
        int n = 0;
        while (!req_valid && n < 50) begin @(negedge clk); n++; end
        chk(req_valid, req, "request never raised", {31'd0, req_valid}, 32'd1);
    endtask

    task automatic ack_req();
        req_ack = 1'b1; @(negedge clk); req_ack = 1'b0;
    endtask

    task automatic respond(input logic [3:0] a, input logic [7:0] d);
        rsp_valid = 1'b1; rsp_addr = a; rsp_data = d;
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); rx_done_clr = 1'b1; @(negedge clk); rx_done_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(host_rdata == 32'h0, "R1", "word after reset", host_rdata, 32'h0);
        chk(!rx_done && !req_valid, "R1", "flag/request after reset",
            {30'd0, rx_done, req_valid}, 32'h0);
    endtask

    task automatic t_store();
        host_wr(cmd(0, 1, 4'h3, 8'hA5));
        chk(host_rdata == cmd(0, 1, 4'h3, 8'hA5), "R2", "field readback",
            host_rdata, cmd(0, 1, 4'h3, 8'hA5));
        wait_req("R4");
        chk(req_is_write && req_addr == 4'h3 && req_data == 8'hA5, "R4", "store fields",
            {19'd0, req_is_write, req_addr, req_data}, {19'd0, 1'b1, 4'h3, 8'hA5});
        repeat (2) @(negedge clk);
        chk(req_valid && req_addr == 4'h3, "R3", "held until ack",
            {27'd0, req_valid, req_addr}, {27'd0, 1'b1, 4'h3});
        ack_req();
        chk(host_rdata[31:30] == 2'b00, "R5", "store bit self-clear",
            {30'd0, host_rdata[31:30]}, 32'h0);
        repeat (3) @(negedge clk);
        chk(!req_valid && !rx_done, "R4", "idle after store ack",
            {30'd0, req_valid, rx_done}, 32'h0);
    endtask

    task automatic t_fetch();
        host_wr(cmd(1, 0, 4'h7, 8'h00));
        wait_req("R3");
        chk(!req_is_write && req_addr == 4'h7, "R3", "fetch fields",
            {27'd0, req_is_write, req_addr}, {27'd0, 1'b0, 4'h7});
        ack_req();
        chk(host_rdata[31:30] == 2'b00, "R5", "fetch bit self-clear",
            {30'd0, host_rdata[31:30]}, 32'h0);
        host_wr(cmd(0, 1, 4'h2, 8'h11));
        chk(host_rdata[31:16] == 16'h0700, "R9", "write while awaiting response",
            {16'd0, host_rdata[31:16]}, 32'h0700);
        repeat (3) @(negedge clk);
        chk(!req_valid, "R9", "no request from ignored write", {31'd0, req_valid}, 32'h0);
        respond(4'h7, 8'h3C);
        chk(rx_done && host_rdata[11:0] == 12'h73C, "R6", "capture",
            {19'd0, rx_done, host_rdata[11:0]}, {19'd0, 1'b1, 12'h73C});
    endtask

    task automatic t_clear();
        pulse_clr();
        chk(!rx_done, "R7", "flag cleared", {31'd0, rx_done}, 32'h0);
        host_wr(cmd(1, 0, 4'h9, 8'h00));
        wait_req("R7"); ack_req(); respond(4'h9, 8'h5E);
        chk(rx_done && host_rdata[11:0] == 12'h95E, "R7", "set again, overwritten",
            {19'd0, rx_done, host_rdata[11:0]}, {19'd0, 1'b1, 12'h95E});
        pulse_clr();
    endtask

    task automatic t_both();
        host_wr(cmd(1, 1, 4'h4, 8'h77));
        chk(host_rdata[31:30] == 2'b10, "R8", "fetch kept, store dropped",
            {30'd0, host_rdata[31:30]}, 32'h2);
        wait_req("R8");
        chk(!req_is_write && req_addr == 4'h4, "R8", "fetch sent",
            {27'd0, req_is_write, req_addr}, {27'd0, 1'b0, 4'h4});
        ack_req(); respond(4'h4, 8'h01);
        repeat (5) @(negedge clk);
        chk(!req_valid, "R8", "no store follows", {31'd0, req_valid}, 32'h0);
        pulse_clr();
    endtask

    task automatic t_busy_send();
        host_wr(cmd(1, 0, 4'h6, 8'h00));
        wait_req("R9");
        host_wr(cmd(0, 1, 4'h1, 8'h99));
        chk(host_rdata[31:16] == 16'h8600, "R9", "write while sending",
            {16'd0, host_rdata[31:16]}, 32'h8600);
        chk(req_valid && req_addr == 4'h6, "R9", "request untouched",
            {27'd0, req_valid, req_addr}, {27'd0, 1'b1, 4'h6});
        ack_req(); respond(4'h6, 8'h42);
        pulse_clr();
    endtask

    task automatic t_auto();
        @(negedge clk); selfid_done = 1'b1; @(negedge clk); selfid_done = 1'b0;
        wait_req("R10");
        chk(!req_is_write && req_addr == 4'h0 && host_rdata[31:30] == 2'b00, "R10",
            "auto fetch of reg 0", {26'd0, host_rdata[31:30], req_addr},
            {26'd0, 2'b00, 4'h0});
        ack_req(); respond(4'h0, 8'h8A);
        chk(rx_done && host_rdata[11:0] == 12'h08A, "R10", "auto capture",
            {19'd0, rx_done, host_rdata[11:0]}, {19'd0, 1'b1, 12'h08A});
        pulse_clr();
    endtask

    task automatic t_defer();
        host_wr(cmd(0, 1, 4'h5, 8'h22));
        wait_req("R11");
        @(negedge clk); selfid_done = 1'b1; @(negedge clk); selfid_done = 1'b0;
        chk(req_valid && req_is_write && req_addr == 4'h5, "R11", "host store not preempted",
            {26'd0, req_valid, req_is_write, req_addr}, {26'd0, 2'b11, 4'h5});
        ack_req();
        wait_req("R11");
        chk(!req_is_write && req_addr == 4'h0, "R11", "deferred auto fetch",
            {27'd0, req_is_write, req_addr}, 32'h0);
        ack_req(); respond(4'h0, 8'h13);
        pulse_clr();
    endtask

    task automatic t_tie();
        @(negedge clk);
        selfid_done = 1'b1; host_wr_en = 1'b1; host_wdata = cmd(0, 1, 4'h8, 8'h44);
        @(negedge clk);
        selfid_done = 1'b0; host_wr_en = 1'b0;
        wait_req("R11");
        chk(req_is_write && req_addr == 4'h8, "R11", "host wins same-cycle tie",
            {27'd0, req_is_write, req_addr}, {27'd0, 1'b1, 4'h8});
        ack_req();
        wait_req("R11");
        chk(!req_is_write && req_addr == 4'h0, "R11", "auto fetch after tie",
            {27'd0, req_is_write, req_addr}, 32'h0);
        ack_req(); respond(4'h0, 8'h55);
        chk(host_rdata[11:0] == 12'h055, "R11", "tie capture",
            {20'd0, host_rdata[11:0]}, 32'h055);
        pulse_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_fetch();
        t_clear();
        t_both();
        t_busy_send();
        t_auto();
        t_defer();
        t_tie();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule